// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block holds recently used virtual-to-physical page translations so that most memory accesses skip a page-table walk. Each lookup presents a virtual address, an address-space identifier and an access kind (read or write). All entries are compared at once. The block answers in the same cycle with a translated physical address, a miss, or a protection fault. A walker or exception handler that services a miss installs the translation through the fill port.

Each entry records the owning address space, so translations from different processes can share the structure without aliasing. Each entry maps either a 4 KB base page or a larger page of 16 KB, 64 KB or 256 KB. Each entry also tracks whether it may be written, whether it has been used, and whether it has been written through. Software can discard every entry, or only the entries of one address space, in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup whose identifier and page match a valid entry raises `lk_hit`. The physical address is the entry's physical page joined to the untranslated offset bits of `lk_vaddr`. For a 4 KB page, bits 11:0 pass through unchanged.
- R3: An entry matches only when its stored identifier equals `lk_asid`. The same virtual address under a different identifier misses.
- R4: The 2-bit size code s (0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = 256 KB) makes the low 12+2s address bits the page offset. Those bits take no part in the tag compare and are copied from `lk_vaddr` into `lk_paddr`. The higher bits come from the physical page.
- R5: A write lookup that matches an entry whose writeable bit is 0 raises `lk_fault` instead of `lk_hit`, drives `lk_paddr` to 0, and leaves that entry's used and written bits unchanged.
- R6: `lk_ref` and `lk_mod` report the matched entry's used and written bits as they stood before the lookup. A hit sets the used bit at the next clock edge. A write hit also sets the written bit at that edge.
- R7: A fill goes into the lowest-numbered invalid entry when one exists. When every entry is valid, a fill goes into the entry named by a round-robin pointer. The pointer starts at entry 0 and moves on by one after each such replacement.
- R8: `flush_all` invalidates every entry at the next clock edge. In that cycle it takes priority over a fill.
- R9: `flush_asid_en` invalidates, in one cycle, only the entries whose identifier equals `flush_asid`. Entries of other identifiers stay valid.
- R10: A fill stores the identifier, page tag, size code, physical page and writeable bit, and clears the entry's used and written bits.
- R11: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is raised, and `lk_miss` is raised exactly when no valid entry matches. With `lk_valid` low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a write access |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No valid matching entry |
| lk_fault | output | 1 | Write to a non-writeable page |
| lk_paddr | output | PA_W | Translated address, 0 unless hit |
| lk_ref | output | 1 | Used bit of the matched entry before this access |
| lk_mod | output | 1 | Written bit of the matched entry before this access |
| fill_valid | input | 1 | Install a translation |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_vpn | input | VA_W-12 | Virtual page tag, in 4 KB units |
| fill_size | input | 2 | Page size code |
| fill_ppn | input | PA_W-12 | Physical page, in 4 KB units |
| fill_wr | input | 1 | Writeable bit of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
The bench fills up to about a hundred random mappings of mixed sizes, identifiers and write permissions. It then looks them up with random offsets. Some lookups use a wrong identifier and some use unrelated addresses, which separates a correct tag compare from one that ignores the identifier or the size mask. Reading an entry twice, and writing it before and after a read, separates the used and written updates from the pre-update report. A write to a read-only page separates fault handling from a plain hit. Directed cases fill the array completely and then add two more translations, which shows whether replacement follows the round-robin order. They also flush one identifier next to another, which shows whether the per-identifier flush is selective.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int BASE_SHIFT = 12;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_16K  = 2'd1,
    PG_64K  = 2'd2,
    PG_256K = 2'd3
  } pg_size_e;

  // number of offset bits beyond the base page for a size code
  function automatic int unsigned extra_shift(logic [1:0] sz);
    return 2 * int'(sz);
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]   tag_q  [ENTRIES],
  input  logic [ASID_W-1:0]  asid_q [ENTRIES],
  input  logic [1:0]         size_q [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASID_W-1:0]  asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [IDX_W-1:0]   match_idx
);
  import tlb_pkg::*;

  // bits of the page tag that take part in the compare
  function automatic logic [VPN_W-1:0] keep_mask(logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    m = m << extra_shift(sz);
    return m;
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = valid[i] && (asid_q[i] == asid) &&
                          (((tag_q[i] ^ vpn) & keep_mask(size_q[i])) == '0);
  end

  assign any_match = |match_vec;

  // lowest index wins
  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   fill_idx,
  output logic               use_rr
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  assign use_rr   = !have_free;
  assign fill_idx = have_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_go && use_rr) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_rr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= IDX_W'(ENTRIES - 1));

  p_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && use_rr && rr_q != IDX_W'(ENTRIES - 1)) |=> (rr_q == $past(rr_q) + 1'b1));

  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_rr) |-> !valid[fill_idx]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 128,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int VPN_W  = VA_W - tlb_pkg::BASE_SHIFT,
  localparam int PPN_W  = PA_W - tlb_pkg::BASE_SHIFT,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_ref,
  output logic              lk_mod,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [1:0]        fill_size,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_wr,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  import tlb_pkg::*;

  // entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] mod_q;
  logic [ENTRIES-1:0] wr_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];

  // named internal events
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic               use_rr;
  logic               perm_block;
  logic               sts_touch;
  logic               fill_go;

  // join the physical page with the untranslated offset bits
  function automatic logic [PA_W-1:0] form_paddr(logic [PPN_W-1:0] ppn,
                                                 logic [VA_W-1:0] va,
                                                 logic [1:0] sz);
    logic [PA_W-1:0] low;
    logic [PA_W-1:0] base;
    low  = '1;
    low  = ~(low << (BASE_SHIFT + extra_shift(sz)));
    base = {ppn, {BASE_SHIFT{1'b0}}};
    return (base & ~low) | (PA_W'(va) & low);
  endfunction

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .valid     (valid_q),
    .tag_q     (tag_q),
    .asid_q    (asid_q),
    .size_q    (size_q),
    .vpn       (lk_vaddr[VA_W-1:BASE_SHIFT]),
    .asid      (lk_asid),
    .match_vec (match_vec),
    .any_match (any_match),
    .match_idx (hit_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid_q),
    .fill_go  (fill_go),
    .fill_idx (fill_idx),
    .use_rr   (use_rr)
  );

  assign fill_go    = fill_valid && !flush_all;
  assign perm_block = lk_write && !wr_q[hit_idx];

  assign lk_miss  = lk_valid && !any_match;
  assign lk_fault = lk_valid && any_match && perm_block;
  assign lk_hit   = lk_valid && any_match && !perm_block;
  assign sts_touch = lk_hit;

  assign lk_paddr = lk_hit ? form_paddr(ppn_q[hit_idx], lk_vaddr, size_q[hit_idx]) : '0;
  assign lk_ref   = lk_valid && any_match && ref_q[hit_idx];
  assign lk_mod   = lk_valid && any_match && mod_q[hit_idx];

  // status and validity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      if (flush_asid_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
        end
      end
      if (sts_touch) begin
        ref_q[hit_idx] <= 1'b1;
        if (lk_write) mod_q[hit_idx] <= 1'b1;
      end
      if (fill_go) begin
        valid_q[fill_idx] <= 1'b1;
        ref_q[fill_idx]   <= 1'b0;
        mod_q[fill_idx]   <= 1'b0;
      end
    end
  end

  // translation payload
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_idx]  <= fill_vpn;
      asid_q[fill_idx] <= fill_asid;
      size_q[fill_idx] <= fill_size;
      ppn_q[fill_idx]  <= fill_ppn;
      wr_q[fill_idx]   <= fill_wr;
    end
  end

  // ---------------- assertions ----------------
  p_one_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}) && (lk_valid == (lk_hit || lk_miss || lk_fault)));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[BASE_SHIFT-1:0] == lk_vaddr[BASE_SHIFT-1:0]));

  p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (!sts_touch && lk_paddr == '0));

  p_write_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !flush_all && !(fill_go && fill_idx == hit_idx))
      |=> mod_q[$past(hit_idx)] && ref_q[$past(hit_idx)]);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (valid_q[$past(fill_idx)] && !ref_q[$past(fill_idx)] && !mod_q[$past(fill_idx)]));

  p_reset_empty_r1: assert property (@(posedge clk)
    $past(!rst_n) && rst_n |-> (valid_q == '0));
endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int ENTRIES = 128;
  localparam int VA_W = 32, PA_W = 32, ASID_W = 8;
  localparam int VPN_W = VA_W - 12, PPN_W = PA_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_fault, lk_ref, lk_mod;
  logic [PA_W-1:0] lk_paddr;
  logic fill_valid = 0, fill_wr = 0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [1:0] fill_size = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [ASID_W-1:0] flush_asid = '0;

  int n_chk = 0, n_bad = 0;
  int seed = 7;

  always #10 clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) uut (.*);

  // bench model (fill order == slot order after a full flush)
  int m_n;
  logic [ASID_W-1:0] m_asid [ENTRIES];
  logic [VPN_W-1:0]  m_vpn  [ENTRIES];
  logic [1:0]        m_sz   [ENTRIES];
  logic [PPN_W-1:0]  m_ppn  [ENTRIES];
  logic              m_wr   [ENTRIES];
  logic              m_ref  [ENTRIES];
  logic              m_mod  [ENTRIES];

  function automatic longint page_bytes(logic [1:0] sz);
    return longint'(4096) * (longint'(1) << (2 * int'(sz)));
  endfunction

  function automatic logic [PA_W-1:0] exp_paddr(logic [PPN_W-1:0] ppn, logic [VA_W-1:0] va, logic [1:0] sz);
    longint pb, base, v;
    pb = page_bytes(sz);
    base = longint'(ppn) * 4096;
    v = longint'(va);
    return PA_W'((base - (base % pb)) + (v % pb));
  endfunction

  function automatic int model_find(logic [ASID_W-1:0] a, logic [VA_W-1:0] va);
    longint pb;
    for (int i = 0; i < m_n; i++) begin
      pb = page_bytes(m_sz[i]);
      if (m_asid[i] == a && (longint'(m_vpn[i]) * 4096) / pb == longint'(va) / pb) return i;
    end
    return -1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(logic [ASID_W-1:0] a, logic [VPN_W-1:0] vpn, logic [1:0] sz,
                         logic [PPN_W-1:0] ppn, logic wr);
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_vpn = vpn; fill_size = sz; fill_ppn = ppn; fill_wr = wr;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  // result packed as {hit,miss,fault,ref,mod,paddr}
  task automatic do_look(logic [ASID_W-1:0] a, logic [VA_W-1:0] va, logic wr, output logic [PA_W+4:0] res);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_vaddr = va; lk_write = wr;
    #5;
    res = {lk_hit, lk_miss, lk_fault, lk_ref, lk_mod, lk_paddr};
    @(posedge clk); #1;
    lk_valid = 0; lk_write = 0;
  endtask

  task automatic pulse_flush_all();
    @(negedge clk); flush_all = 1; @(posedge clk); #1; flush_all = 0;
    m_n = 0;
  endtask

  function automatic logic [PA_W+4:0] pk(logic h, logic m, logic f, logic r, logic d, logic [PA_W-1:0] p);
    return {h, m, f, r, d, p};
  endfunction

  logic [PA_W+4:0] res;
  logic done = 0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    m_n = 0;

    // R1: empty after reset
    do_look(8'd1, 32'h1234_5678, 0, res);
    check("R1 lookup after reset", res, pk(0, 1, 0, 0, 0, 0));

    // R11: no request, no response
    @(negedge clk); #5;
    check("R11 idle outputs", {lk_hit, lk_miss, lk_fault}, 0);

    // R2 R10: basic 4K hit, fresh status
    do_fill(8'd1, 20'h12345, 2'd0, 20'hABCDE, 1);
    do_look(8'd1, 32'h1234_5678, 0, res);
    check("R2 R10 first read", res, pk(1, 0, 0, 0, 0, 32'hABCD_E678));
    // R6: used bit now set, written still clear
    do_look(8'd1, 32'h1234_5000, 1, res);
    check("R6 write reports ref=1 mod=0", res, pk(1, 0, 0, 1, 0, 32'hABCD_E000));
    do_look(8'd1, 32'h1234_5FFF, 0, res);
    check("R6 written bit set", res, pk(1, 0, 0, 1, 1, 32'hABCD_EFFF));

    // R3: other identifier misses
    do_look(8'd2, 32'h1234_5678, 0, res);
    check("R3 identifier mismatch", res, pk(0, 1, 0, 0, 0, 0));

    // R4 R5: 256K read-only page
    do_fill(8'd1, 20'h40000, 2'd3, 20'h55540, 0);
    do_look(8'd1, 32'h4003_ABCD, 1, res);
    check("R5 write to read-only faults", res, pk(0, 0, 1, 0, 0, 0));
    do_look(8'd1, 32'h4003_ABCD, 0, res);
    check("R4 R5 superpage read, fault left no status",
          res, pk(1, 0, 0, 0, 0, exp_paddr(20'h55540, 32'h4003_ABCD, 2'd3)));
    do_look(8'd1, 32'h4043_ABCD, 0, res);
    check("R4 outside 256K page", res, pk(0, 1, 0, 0, 0, 0));

    // R4: 16K page, bits 13:12 from vaddr
    do_fill(8'd3, 20'h00804, 2'd1, 20'h77777, 1);
    do_look(8'd3, 32'h0080_7123, 0, res);
    check("R4 16K split", res, pk(1, 0, 0, 0, 0, 32'h7777_7123 & 32'hFFFF_C000 | 32'h0000_3123));

    // R9: flush identifier 1 only
    @(negedge clk); flush_asid_en = 1; flush_asid = 8'd1; @(posedge clk); #1; flush_asid_en = 0;
    do_look(8'd1, 32'h1234_5678, 0, res);
    check("R9 flushed identifier gone", res[PA_W+3], 1);
    do_look(8'd3, 32'h0080_4000, 0, res);
    check("R9 other identifier kept", res[PA_W+4], 1);

    // R8: flush everything
    pulse_flush_all();
    do_look(8'd3, 32'h0080_4000, 0, res);
    check("R8 flush all", res, pk(0, 1, 0, 0, 0, 0));

    // R7 R10: fill all slots then replace round-robin
    for (int i = 0; i < ENTRIES; i++) do_fill(8'd0, VPN_W'(i), 2'd0, PPN_W'(i + 256), 1);
    do_look(8'd0, 32'h0000_0010, 0, res);
    check("R7 slot 0 resident when full", res[PA_W+4], 1);
    do_fill(8'd0, 20'h00200, 2'd0, 20'h00999, 1);
    do_look(8'd0, 32'h0000_0010, 0, res);
    check("R7 first victim is slot 0", res[PA_W+3], 1);
    do_look(8'd0, 32'h0000_1010, 0, res);
    check("R7 slot 1 kept", res[PA_W+4], 1);
    do_look(8'd0, 32'h0020_0004, 0, res);
    check("R7 R10 replacement entry fresh", res, pk(1, 0, 0, 0, 0, 32'h0099_9004));
    do_fill(8'd0, 20'h00201, 2'd0, 20'h00998, 1);
    do_look(8'd0, 32'h0000_1010, 0, res);
    check("R7 second victim is slot 1", res[PA_W+3], 1);
    do_look(8'd0, 32'h0000_2010, 0, res);
    check("R7 slot 2 kept", res[PA_W+4], 1);

    // random rounds against model: R2 R3 R4 R5 R6 R11
    for (int r = 0; r < 4; r++) begin
      int n;
      pulse_flush_all();
      n = 40 + int'($urandom(seed + r) % 60);
      for (int i = 0; i < n; i++) begin
        m_asid[i] = ASID_W'($urandom % 4);
        m_vpn[i]  = VPN_W'($urandom);
        m_sz[i]   = 2'($urandom);
        m_ppn[i]  = PPN_W'($urandom);
        m_wr[i]   = 1'($urandom);
        m_ref[i]  = 0; m_mod[i] = 0;
        do_fill(m_asid[i], m_vpn[i], m_sz[i], m_ppn[i], m_wr[i]);
        m_n = i + 1;
      end
      for (int k = 0; k < 300; k++) begin
        logic [ASID_W-1:0] a;
        logic [VA_W-1:0] va;
        logic w;
        int j, e;
        j = int'($urandom % n);
        a = ($urandom % 5 == 0) ? ASID_W'($urandom % 4) : m_asid[j];
        va = {m_vpn[j], 12'h000} ^ VA_W'($urandom % page_bytes(m_sz[j]));
        if ($urandom % 8 == 0) va = VA_W'($urandom);
        w = 1'($urandom);
        e = model_find(a, va);
        do_look(a, va, w, res);
        if (e < 0) begin
          check("R3 R11 random miss", res, pk(0, 1, 0, 0, 0, 0));
        end else if (w && !m_wr[e]) begin
          check("R5 random fault", res, pk(0, 0, 1, m_ref[e], m_mod[e], 0));
        end else begin
          check("R2 R4 R6 random hit", res,
                pk(1, 0, 0, m_ref[e], m_mod[e], exp_paddr(m_ppn[e], va, m_sz[e])));
          m_ref[e] = 1;
          if (w) m_mod[e] = 1;
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule